// File: doc/BRIEF.md
# Strap-Configured Dual-Clock FIFO

A 9-bit wide first-in first-out buffer whose write side and read side run on independent clocks. Write and read pointers are kept in both binary and reflected-binary (gray) form; each side sees the other's gray pointer through a two-flop synchronizer and derives its own occupancy, full/empty and almost-full/almost-empty flags from it. All four flags are active low. Depth is a power-of-two parameter.

The write-side configuration is strapped at reset. While the active-low reset is held, the level on the shared `wen2_ld` pin is captured on each write clock edge. A high level selects dual-enable mode, where a word is stored only when `wen1_n` is low and `wen2_ld` is high. A low level selects programmable-threshold mode. In that mode `wen1_n` is the only write enable, and `wen2_ld` becomes a load strobe. Holding both `wen1_n` and `wen2_ld` low loads threshold values from the data bus instead of storing data. The first load sets the almost-empty threshold, the second sets the almost-full threshold, and further loads keep alternating between the two. The read side takes a word only when both active-low read enables are low.

Top module: `strap_fifo`

## Requirements
- R1: After reset both pointers are zero: `empty_n` is 0, `full_n` is 1 and `dout` is 0.
- R2: The mode is captured only while `rst_n` is low (`wen2_ld`=1 selects dual-enable, 0 selects programmable-threshold) and holds until the next reset; in dual-enable mode `wen1_n`=0 with `wen2_ld`=0 neither stores data nor loads a threshold.
- R3: In dual-enable mode a word is stored on a write clock rising edge only when `wen1_n`=0 and `wen2_ld`=1.
- R4: In programmable-threshold mode a word is stored on a write clock rising edge when `wen1_n`=0 and `wen2_ld`=1.
- R5: In programmable-threshold mode an edge with `wen1_n`=0 and `wen2_ld`=0 loads `din[ADDR_W-1:0]` into a threshold register and stores no data; loads alternate almost-empty, almost-full, almost-empty, and so on, starting with almost-empty after each reset.
- R6: While `full_n` is 0 no word is stored and the stored contents are unchanged, whatever the enables.
- R7: A word is read on a read clock rising edge only when `ren1_n`=0 and `ren2_n`=0; with either enable high, `dout` and the occupancy stay unchanged.
- R8: While `empty_n` is 0 a read attempt leaves `dout` and the read pointer unchanged, so the next word written is the next word read.
- R9: Words leave in the order they were stored, each read placing the word on `dout` at the read clock edge that takes it.
- R10: Once the pointers have settled, `aempty_n` is 0 exactly when the occupancy is at or below the almost-empty threshold.
- R11: Once the pointers have settled, `afull_n` is 0 exactly when the free space (depth minus occupancy) is at or below the almost-full threshold.
- R12: Both thresholds reset to 7, so after reset `aempty_n` is 0 and `afull_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides; mode strap sampled while low |
| din | input | 9 | Write data, also the threshold source on loads |
| wen1_n | input | 1 | Primary write enable, active low |
| wen2_ld | input | 1 | Second write enable (high active) or load strobe (low active), by mode |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| dout | output | 9 | Read data, registered |
| full_n | output | 1 | Full flag, active low |
| afull_n | output | 1 | Almost-full flag, active low |
| empty_n | output | 1 | Empty flag, active low |
| aempty_n | output | 1 | Almost-empty flag, active low |

## Verification
The bench builds the block with a 16-entry depth (ADDR_W = 4) and the default reset threshold of 7, so every occupancy from empty to full is visited in each mode. Both thresholds can cross any level in that range, and the flags are compared at each step. Reaching full within a few dozen writes lets the bench push extra writes while full and read while empty in the same run. It also sweeps a threshold loaded by a third, wrapped load.

// File: rtl/sfifo_pkg.sv
`timescale 1ns/1ps
package sfifo_pkg;

  localparam int PW_MAX = 16;
  typedef logic [PW_MAX-1:0] ptr_t;

  typedef enum logic {
    MODE_PFLAG = 1'b0,
    MODE_DUAL  = 1'b1
  } wmode_e;

  function automatic ptr_t bin_to_gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray_to_bin(ptr_t g);
    ptr_t b;
    b[PW_MAX-1] = g[PW_MAX-1];
    for (int i = PW_MAX - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // occupancy between two pointers of pw bits, wrap-around safe
  function automatic ptr_t fill_level(ptr_t head, ptr_t tail, int unsigned pw);
    ptr_t d;
    d = head - tail;
    return d & ((ptr_t'(1) << pw) - ptr_t'(1));
  endfunction

  function automatic logic at_or_below(ptr_t level, ptr_t limit);
    return level <= limit;
  endfunction

endpackage

// File: rtl/sfifo_sync2.sv
`timescale 1ns/1ps
module sfifo_sync2 #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/sfifo_mem.sv
`timescale 1ns/1ps
module sfifo_mem #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 6
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/sfifo_wr_ctl.sv
`timescale 1ns/1ps
module sfifo_wr_ctl
  import sfifo_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int OFF_W   = 6,
  parameter int OFF_RST = 7
) (
  input  logic              wr_clk,
  input  logic              rst_n,
  input  logic              wen1_n,
  input  logic              wen2_ld,
  input  logic [OFF_W-1:0]  ld_data,
  input  logic [ADDR_W:0]   rgray_sync,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wgray,
  output logic [OFF_W-1:0]  ae_off,
  output logic              full_n,
  output logic              afull_n
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  wmode_e           mode_q;
  logic [PTR_W-1:0] wbin_q;
  logic [PTR_W-1:0] wbin_nx;
  logic [PTR_W-1:0] rbin_seen;
  logic [PTR_W-1:0] occ;
  logic [PTR_W-1:0] space;
  logic [OFF_W-1:0] af_off;
  logic             ld_sel_q;
  logic             wr_req;
  logic             ld_fire;
  logic             full;

  // strap: pin level captured on every write edge while reset is held
  always_ff @(posedge wr_clk) begin
    if (!rst_n) mode_q <= wen2_ld ? MODE_DUAL : MODE_PFLAG;
  end

  assign wr_req  = !wen1_n && wen2_ld;
  assign ld_fire = (mode_q == MODE_PFLAG) && !wen1_n && !wen2_ld;

  assign rbin_seen = PTR_W'(gray_to_bin(ptr_t'(rgray_sync)));
  assign occ       = PTR_W'(fill_level(ptr_t'(wbin_q), ptr_t'(rbin_seen), PTR_W));
  assign space     = PTR_W'(DEPTH) - occ;
  assign full      = (occ == PTR_W'(DEPTH));
  assign full_n    = !full;
  assign afull_n   = !at_or_below(ptr_t'(space), ptr_t'(af_off));

  assign wr_fire = wr_req && !full;
  assign wbin_nx = wbin_q + PTR_W'(1);
  assign waddr   = wbin_q[ADDR_W-1:0];

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q <= '0;
      wgray  <= '0;
    end else if (wr_fire) begin
      wbin_q <= wbin_nx;
      wgray  <= PTR_W'(bin_to_gray(ptr_t'(wbin_nx)));
    end
  end

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_off   <= OFF_W'(OFF_RST);
      af_off   <= OFF_W'(OFF_RST);
      ld_sel_q <= 1'b0;
    end else if (ld_fire) begin
      if (!ld_sel_q) ae_off <= ld_data;
      else           af_off <= ld_data;
      ld_sel_q <= !ld_sel_q;
    end
  end

  AST_MODE_HELD: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q)); // R2
  AST_WRITE_QUAL: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wbin_q != $past(wbin_q)) |-> $past(!wen1_n && wen2_ld)); // R3
  AST_LOAD_NO_WRITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
    ld_fire |=> $stable(wbin_q)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wbin_q != $past(wbin_q)) |-> $past(full_n)); // R6
  AST_OCC_BOUND: assert property (@(posedge wr_clk) disable iff (!rst_n)
    occ <= PTR_W'(DEPTH)); // R6
endmodule

// File: rtl/sfifo_rd_ctl.sv
`timescale 1ns/1ps
module sfifo_rd_ctl
  import sfifo_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int OFF_W  = 6
) (
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic [ADDR_W:0]   wgray_sync,
  input  logic [OFF_W-1:0]  ae_off,
  output logic              rd_fire,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rgray,
  output logic              empty_n,
  output logic              aempty_n
);
  localparam int PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0] rbin_q;
  logic [PTR_W-1:0] rbin_nx;
  logic [PTR_W-1:0] wbin_seen;
  logic [PTR_W-1:0] occ;
  logic             empty;
  logic             rd_req;

  assign wbin_seen = PTR_W'(gray_to_bin(ptr_t'(wgray_sync)));
  assign occ       = PTR_W'(fill_level(ptr_t'(wbin_seen), ptr_t'(rbin_q), PTR_W));
  assign empty     = (occ == '0);
  assign empty_n   = !empty;
  assign aempty_n  = !at_or_below(ptr_t'(occ), ptr_t'(ae_off));

  assign rd_req  = !ren1_n && !ren2_n;
  assign rd_fire = rd_req && !empty;
  assign rbin_nx = rbin_q + PTR_W'(1);
  assign raddr   = rbin_q[ADDR_W-1:0];

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q <= '0;
      rgray  <= '0;
    end else if (rd_fire) begin
      rbin_q <= rbin_nx;
      rgray  <= PTR_W'(bin_to_gray(ptr_t'(rbin_nx)));
    end
  end

  AST_READ_QUAL: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rbin_q != $past(rbin_q)) |-> $past(!ren1_n && !ren2_n)); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rbin_q != $past(rbin_q)) |-> $past(empty_n)); // R8
  AST_ONE_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1); // R9
endmodule

// File: rtl/strap_fifo.sv
`timescale 1ns/1ps
module strap_fifo #(
  parameter int DATA_W     = 9,
  parameter int ADDR_W     = 6,
  parameter int OFFS_RESET = 7
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              wen1_n,
  input  logic              wen2_ld,
  input  logic              ren1_n,
  input  logic              ren2_n,
  output logic [DATA_W-1:0] dout,
  output logic              full_n,
  output logic              afull_n,
  output logic              empty_n,
  output logic              aempty_n
);
  localparam int OFF_W = ADDR_W;
  localparam int PTR_W = ADDR_W + 1;

  logic              wr_fire;
  logic              rd_fire;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic [PTR_W-1:0]  wgray;
  logic [PTR_W-1:0]  rgray;
  logic [PTR_W-1:0]  wgray_at_rd;
  logic [PTR_W-1:0]  rgray_at_wr;
  logic [OFF_W-1:0]  ae_off;

  sfifo_wr_ctl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .OFF_RST(OFFS_RESET)) u_wr (
    .wr_clk     (wr_clk),
    .rst_n      (rst_n),
    .wen1_n     (wen1_n),
    .wen2_ld    (wen2_ld),
    .ld_data    (din[OFF_W-1:0]),
    .rgray_sync (rgray_at_wr),
    .wr_fire    (wr_fire),
    .waddr      (waddr),
    .wgray      (wgray),
    .ae_off     (ae_off),
    .full_n     (full_n),
    .afull_n    (afull_n)
  );

  sfifo_sync2 #(.W(PTR_W)) u_sync_w2r (
    .clk (rd_clk), .rst_n (rst_n), .d (wgray), .q (wgray_at_rd)
  );

  sfifo_sync2 #(.W(PTR_W)) u_sync_r2w (
    .clk (wr_clk), .rst_n (rst_n), .d (rgray), .q (rgray_at_wr)
  );

  sfifo_rd_ctl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_rd (
    .rd_clk     (rd_clk),
    .rst_n      (rst_n),
    .ren1_n     (ren1_n),
    .ren2_n     (ren2_n),
    .wgray_sync (wgray_at_rd),
    .ae_off     (ae_off),
    .rd_fire    (rd_fire),
    .raddr      (raddr),
    .rgray      (rgray),
    .empty_n    (empty_n),
    .aempty_n   (aempty_n)
  );

  sfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk (wr_clk),
    .we     (wr_fire),
    .waddr  (waddr),
    .wdata  (din),
    .rd_clk (rd_clk),
    .rst_n  (rst_n),
    .re     (rd_fire),
    .raddr  (raddr),
    .rdata  (dout)
  );

  AST_DOUT_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !$past(rd_fire) |-> $stable(dout)); // R7
endmodule

// File: tb/strap_fifo_test.sv
`timescale 1ns/1ps
module strap_fifo_test;
  localparam int AW    = 4;
  localparam int DW    = 9;
  localparam int DEPTH = 1 << AW;

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          rst_n  = 1'b0;
  logic [DW-1:0] din    = '0;
  logic          wen1_n = 1'b1;
  logic          wen2_ld = 1'b1;
  logic          ren1_n = 1'b1;
  logic          ren2_n = 1'b1;
  logic [DW-1:0] dout;
  logic          full_n, afull_n, empty_n, aempty_n;

  int checks = 0;
  int errors = 0;
  int model[$];
  int ae_exp = 7;
  int af_exp = 7;

  strap_fifo #(.DATA_W(DW), .ADDR_W(AW), .OFFS_RESET(7)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .din(din),
    .wen1_n(wen1_n), .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .dout(dout), .full_n(full_n), .afull_n(afull_n),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
    #1;
  endtask

  task automatic check_flags(string req);
    int occ;
    occ = model.size();
    check({req, " empty_n"},  int'(empty_n),  int'(occ != 0));
    check({req, " full_n"},   int'(full_n),   int'(occ != DEPTH));
    check({req, " R10 aempty_n"}, int'(aempty_n), int'(!(occ <= ae_exp)));
    check({req, " R11 afull_n"},  int'(afull_n),  int'(!((DEPTH - occ) <= af_exp)));
  endtask

  task automatic do_reset(logic strap);
    wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    wen2_ld = strap;
    @(negedge wr_clk);
    rst_n = 1'b0;
    repeat (4) @(posedge wr_clk);
    repeat (2) @(posedge rd_clk);
    @(negedge wr_clk);
    rst_n = 1'b1;
    @(negedge wr_clk);
    wen2_ld = 1'b1;
    model.delete();
    ae_exp = 7;
    af_exp = 7;
    settle();
  endtask

  task automatic wr_cycle(logic w1n, logic w2, int data);
    @(negedge wr_clk);
    wen1_n = w1n; wen2_ld = w2; din = DW'(data);
    @(negedge wr_clk);
    wen1_n = 1'b1; wen2_ld = 1'b1;
  endtask

  task automatic rd_cycle(logic r1n, logic r2n);
    @(negedge rd_clk);
    ren1_n = r1n; ren2_n = r2n;
    @(negedge rd_clk);
    ren1_n = 1'b1; ren2_n = 1'b1;
    #1;
  endtask

  task automatic push(string req, int data);
    wr_cycle(1'b0, 1'b1, data);
    if (model.size() < DEPTH) model.push_back(data);
    settle();
    check_flags(req);
  endtask

  task automatic pop(string req);
    int exp;
    rd_cycle(1'b0, 1'b0);
    exp = model.pop_front();
    check({req, " R9 dout"}, int'(dout), exp);
    settle();
    check_flags(req);
  endtask

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int last;

    // ---- dual-enable mode ----
    do_reset(1'b1);
    check("R1 empty_n", int'(empty_n), 0);
    check("R1 full_n", int'(full_n), 1);
    check("R1 dout", int'(dout), 0);
    check("R12 aempty_n", int'(aempty_n), 0);
    check("R12 afull_n", int'(afull_n), 1);

    // R3: qualifiers that must not store
    wr_cycle(1'b0, 1'b0, 9'h055);   // R2: also no load in dual mode
    wr_cycle(1'b1, 1'b1, 9'h066);
    wr_cycle(1'b1, 1'b0, 9'h077);
    settle();
    check("R3 no store empty_n", int'(empty_n), 0);

    // R3 and R12 (thresholds stay 7 after the attempted load, R2)
    for (int i = 0; i < DEPTH; i++) push("R3 fill", (i * 37 + 5) & 9'h1FF);

    // R6: writes while full are dropped
    for (int i = 0; i < 3; i++) push("R6 full", 9'h1F0 + i);

    // R7: one read enable only
    rd_cycle(1'b0, 1'b1);
    settle();
    check("R7 ren2 high dout", int'(dout), 0);
    check("R7 ren2 high full_n", int'(full_n), 0);
    rd_cycle(1'b1, 1'b0);
    settle();
    check("R7 ren1 high dout", int'(dout), 0);
    check("R7 ren1 high full_n", int'(full_n), 0);

    // R9/R6: drain in order, no trace of dropped words
    for (int i = 0; i < DEPTH; i++) pop("R6 drain");
    last = int'(dout);

    // R8: read on empty
    rd_cycle(1'b0, 1'b0);
    settle();
    check("R8 empty dout", int'(dout), last);
    check("R8 empty_n", int'(empty_n), 0);
    push("R8 refill", 9'h1A5);
    pop("R8 next word");

    // R2: strap taken only in reset; wen2_ld low after reset stays dual
    wr_cycle(1'b0, 1'b0, 9'h003);
    settle();
    check("R2 dual kept", int'(empty_n), 0);

    // ---- programmable-threshold mode ----
    do_reset(1'b0);
    check("R1 pflag empty_n", int'(empty_n), 0);
    check("R12 pflag aempty_n", int'(aempty_n), 0);
    wr_cycle(1'b0, 1'b0, 3);
    wr_cycle(1'b0, 1'b0, 5);
    ae_exp = 3;
    af_exp = 5;
    settle();
    check("R5 no store empty_n", int'(empty_n), 0);
    check_flags("R5 loaded");

    for (int i = 0; i < DEPTH; i++) push("R4 fill", (i * 53 + 11) & 9'h1FF);
    push("R6 pflag full", 9'h0AA);
    for (int i = 0; i < DEPTH; i++) pop("R4 drain");

    // R5: third load wraps to almost-empty
    wr_cycle(1'b0, 1'b0, 12);
    ae_exp = 12;
    settle();
    check_flags("R5 wrap");
    for (int i = 0; i < 14; i++) push("R5 wrap fill", i + 100);
    for (int i = 0; i < 14; i++) pop("R5 wrap drain");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule